// File: doc/BRIEF.md
# Condition-Tagged Dataflow Operator

This block is one processing node of a data-driven array. Each channel moves a data word together with a single condition flag, and a channel moves a token only when valid and ready are both high in the same cycle. The node waits for the operand tokens its operation needs and consumes them in one handshake. It then produces exactly one output token and holds it until the downstream side takes it.

When the combined incoming condition is true, the node computes its selected operation. The operations are add, subtract, bitwise AND, OR and XOR, and routing of channel A. The result leaves with the condition set. When the combined condition is false, the computation is skipped. A zero data word with a cleared condition is sent on the fast path, one cycle sooner than a computed result.

A merge mode joins the two arms of an if/then/else. Channel A carries the then-arm and channel B the else-arm. The node forwards the arm whose condition is true. Chaining such nodes lets nested conditionals run in dataflow form.

Top module: `cdf_node`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge until a token is accepted, `y_valid` is low.
- R2: For a true token, `y_data` is the operation on `a_data` and `b_data`, selected by `op_sel`: 0 add, 1 subtract (A minus B, modulo 2^32), 2 AND, 3 OR, 4 XOR. Routing (5 and 7) yields `a_data`.
- R3: For add, subtract and the logic operations, the output condition is the AND of the two input conditions. Any output token with `y_cond` low carries `y_data` equal to zero.
- R4: A token whose combined condition is false raises `y_valid` after the single clock edge that accepts it.
- R5: A token whose combined condition is true keeps `y_valid` low after the accepting edge and raises it after the following edge.
- R6: In routing modes (`op_sel` 5 or 7), only channel A is used. `b_ready` stays low and the output condition equals `a_cond`.
- R7: Outside the routing modes, a token is accepted only when both `a_valid` and `b_valid` are high. `a_ready` and `b_ready` then rise together in that cycle.
- R8: In merge mode (`op_sel` 6), the output carries the data of the arm whose condition is true. If both are false, the output is a false token on the fast path. If both are true, the output carries the then-arm data with `y_cond` and `y_merge_err` high.
- R9: While `y_valid` is high and `y_ready` is low, the output token holds unchanged and no input is accepted.
- R10: `op_sel` is taken at the accepting edge. Changing it later does not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation select |
| a_valid | input | 1 | Channel A token present |
| a_ready | output | 1 | Channel A token taken this cycle |
| a_data | input | 32 | Channel A data word |
| a_cond | input | 1 | Channel A condition (then-arm in merge) |
| b_valid | input | 1 | Channel B token present |
| b_ready | output | 1 | Channel B token taken this cycle |
| b_data | input | 32 | Channel B data word |
| b_cond | input | 1 | Channel B condition (else-arm in merge) |
| y_valid | output | 1 | Output token present |
| y_ready | input | 1 | Downstream takes the output token |
| y_data | output | 32 | Output data word |
| y_cond | output | 1 | Output condition |
| y_merge_err | output | 1 | Merge saw two true arms |

## Verification
Several properties are checked on every cycle:
- the one-cycle latency of false tokens and the two-cycle latency of true tokens;
- the output holding stable under backpressure;
- the pairing of the two ready signals;
- zero data on false tokens;
- an error flag appearing only on a true token.

Only the bench's scenarios can show the rest: that the arithmetic and logic results have the right values, which merge arm is chosen, that routing ignores channel B, and that `op_sel` is latched at acceptance and not read later.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_PASS  = 3'd5,
        OP_MERGE = 3'd6,
        OP_PASS2 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_SEND = 2'd2
    } st_e;

    typedef struct packed {
        logic cond;
        logic err;
    } flag_t;

    // channel B takes part unless the node only routes A
    function automatic logic uses_b(op_e op);
        return !(op == OP_PASS || op == OP_PASS2);
    endfunction

    // condition carried by the token formed from the inputs
    function automatic logic tok_cond(op_e op, logic ac, logic bc);
        logic c;
        case (op)
            OP_MERGE:          c = ac | bc;
            OP_PASS, OP_PASS2: c = ac;
            default:           c = ac & bc;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cdf_alu.sv
module cdf_alu
    import cdf_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/cdf_merge.sv
module cdf_merge
    import cdf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] then_d,
    input  logic          then_c,
    input  logic [DW-1:0] else_d,
    input  logic          else_c,
    output logic [DW-1:0] out_d,
    output flag_t         out_f
);

    always_comb begin
        if (then_c)      out_d = then_d;
        else if (else_c) out_d = else_d;
        else             out_d = '0;
        out_f.cond = then_c | else_c;
        out_f.err  = then_c & else_c;
    end

endmodule

// File: rtl/cdf_ctrl.sv
module cdf_ctrl
    import cdf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_valid,
    input  logic b_valid,
    input  logic need_b,
    input  logic tok_true,
    input  logic y_ready,
    output logic fire,
    output logic in_exec,
    output logic y_valid
);

    st_e st, st_nx;

    assign fire    = (st == ST_IDLE) && a_valid && (b_valid || !need_b);
    assign in_exec = (st == ST_EXEC);
    assign y_valid = (st == ST_SEND);

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (fire) st_nx = tok_true ? ST_EXEC : ST_SEND;
            ST_EXEC: st_nx = ST_SEND;
            ST_SEND: if (y_ready) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    // R4
    false_fast_chk: assert property (@(posedge clk) disable iff (rst)
        fire && !tok_true |=> y_valid);

    // R5
    true_slow_chk: assert property (@(posedge clk) disable iff (rst)
        fire && tok_true |=> !y_valid);

    // R5
    exec_done_chk: assert property (@(posedge clk) disable iff (rst)
        in_exec |=> y_valid);

    // R9
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid && !y_ready |=> y_valid);

endmodule

// File: rtl/cdf_node.sv
module cdf_node
    import cdf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_sel,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_cond,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_cond,
    output logic              y_valid,
    input  logic              y_ready,
    output logic [DATA_W-1:0] y_data,
    output logic              y_cond,
    output logic              y_merge_err
);

    op_e               op_in, op_q;
    logic              need_b, tok_true, fire, in_exec;
    logic [DATA_W-1:0] a_q, b_q, alu_res, mrg_d;
    logic              ac_q, bc_q;
    flag_t             mrg_f;
    logic [DATA_W-1:0] yd_q;
    flag_t             yf_q;

    assign op_in    = op_e'(op_sel);
    assign need_b   = uses_b(op_in);
    assign tok_true = tok_cond(op_in, a_cond, b_cond);

    cdf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .a_valid  (a_valid),
        .b_valid  (b_valid),
        .need_b   (need_b),
        .tok_true (tok_true),
        .y_ready  (y_ready),
        .fire     (fire),
        .in_exec  (in_exec),
        .y_valid  (y_valid)
    );

    assign a_ready = fire;
    assign b_ready = fire && need_b;

    // operands captured at acceptance, op latched with them
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_ADD;
            a_q  <= '0;
            b_q  <= '0;
            ac_q <= 1'b0;
            bc_q <= 1'b0;
        end else if (fire) begin
            op_q <= op_in;
            a_q  <= a_data;
            b_q  <= b_data;
            ac_q <= a_cond;
            bc_q <= b_cond;
        end
    end

    cdf_alu #(.DW(DATA_W)) u_alu (
        .op  (op_q),
        .a   (a_q),
        .b   (b_q),
        .res (alu_res)
    );

    cdf_merge #(.DW(DATA_W)) u_merge (
        .then_d (a_q),
        .then_c (ac_q),
        .else_d (b_q),
        .else_c (bc_q),
        .out_d  (mrg_d),
        .out_f  (mrg_f)
    );

    // false tokens load the output directly; true ones one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            yd_q <= '0;
            yf_q <= '0;
        end else if (fire && !tok_true) begin
            yd_q <= '0;
            yf_q <= '0;
        end else if (in_exec) begin
            if (op_q == OP_MERGE) begin
                yd_q <= mrg_d;
                yf_q <= mrg_f;
            end else begin
                yd_q      <= alu_res;
                yf_q.cond <= 1'b1;
                yf_q.err  <= 1'b0;
            end
        end
    end

    assign y_data      = yd_q;
    assign y_cond      = yf_q.cond;
    assign y_merge_err = yf_q.err;

    // R9
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid && !y_ready |=> $stable(y_data) && $stable(y_cond) && $stable(y_merge_err));

    // R3
    false_zero_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid && !y_cond |-> y_data == '0);

    // R8
    err_true_chk: assert property (@(posedge clk) disable iff (rst)
        y_valid && y_merge_err |-> y_cond);

    // R7
    pair_ready_chk: assert property (@(posedge clk) disable iff (rst)
        b_ready |-> a_ready && a_valid && b_valid);

endmodule

// File: tb/test_cdf_node.sv
module test_cdf_node;

    localparam int CLK_P = 10;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op_sel = 3'd0;
    logic          a_valid = 1'b0, a_cond = 1'b0, b_valid = 1'b0, b_cond = 1'b0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic          y_ready = 1'b1;
    logic          a_ready, b_ready, y_valid, y_cond, y_merge_err;
    logic [DW-1:0] y_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // reference model state
    logic          m_busy = 1'b0;
    int            m_wait = 0;
    logic [DW-1:0] m_data = '0;
    logic          m_cond = 1'b0, m_err = 1'b0;

    cdf_node #(.DATA_W(DW)) i_cdf_node (
        .clk(clk), .rst(rst), .op_sel(op_sel),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_cond(a_cond),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_cond(b_cond),
        .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .y_cond(y_cond),
        .y_merge_err(y_merge_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_needb(input int op);
        return !(op == 5 || op == 7);
    endfunction

    // behavioural expectation for one accepted token
    task automatic m_eval(input int op, input logic [DW-1:0] ad, input logic ac,
                          input logic [DW-1:0] bd, input logic bc);
        m_err = 1'b0;
        if (op == 6) begin
            m_cond = ac || bc;
            m_err  = ac && bc;
            m_data = ac ? ad : (bc ? bd : '0);
        end else begin
            m_cond = (op == 5 || op == 7) ? ac : (ac && bc);
            case (op)
                0: m_data = ad + bd;
                1: m_data = ad - bd;
                2: m_data = ad & bd;
                3: m_data = ad | bd;
                4: m_data = ad ^ bd;
                default: m_data = ad;
            endcase
            if (!m_cond) m_data = '0;
        end
    endtask

    function automatic bit stop_now();
        return cyc > 20000;
    endfunction

    // per-cycle model, stepped just after each rising edge
    always begin
        @(posedge clk);
        #2;
        cyc++;
        if (rst) begin
            m_busy = 1'b0;
            m_wait = 0;
        end else begin
            bit pre_busy, rdy;
            pre_busy = m_busy;
            if (m_busy && m_wait == 0 && y_ready) m_busy = 1'b0;
            else if (m_busy && m_wait > 0) m_wait--;
            if (!pre_busy && a_valid && (b_valid || !m_needb(int'(op_sel)))) begin
                m_eval(int'(op_sel), a_data, a_cond, b_data, b_cond);
                m_busy = 1'b1;
                m_wait = m_cond ? 1 : 0;
            end
            chk(y_valid == (m_busy && m_wait == 0), "R4 valid timing", DW'(y_valid), DW'(m_busy && m_wait == 0));
            if (m_busy && m_wait == 0) begin
                chk(y_data == m_data, "R2 data", y_data, m_data);
                chk(y_cond == m_cond, "R3 cond", DW'(y_cond), DW'(m_cond));
                chk(y_merge_err == m_err, "R8 err", DW'(y_merge_err), DW'(m_err));
            end
            rdy = !m_busy && a_valid && (b_valid || !m_needb(int'(op_sel)));
            chk(a_ready == rdy, "R7 a_ready", DW'(a_ready), DW'(rdy));
            chk(b_ready == (rdy && m_needb(int'(op_sel))), "R6 b_ready", DW'(b_ready), DW'(rdy && m_needb(int'(op_sel))));
        end
    end

    task automatic present(input int op, input logic [DW-1:0] ad, input logic ac,
                           input logic bv, input logic [DW-1:0] bd, input logic bc);
        bit r;
        @(negedge clk);
        op_sel = op[2:0];
        a_valid = 1'b1; a_data = ad; a_cond = ac;
        b_valid = bv;   b_data = bd; b_cond = bc;
        do begin
            #1 r = a_ready;
            @(posedge clk);
            if (!r) @(negedge clk);
        end while (!r && !stop_now());
    endtask

    task automatic run_tok(input int op, input logic [DW-1:0] ad, input logic ac,
                           input logic bv, input logic [DW-1:0] bd, input logic bc,
                           input logic [DW-1:0] ed, input logic ec, input logic ee,
                           input string tag, input int newop);
        present(op, ad, ac, bv, bd, bc);
        #2;
        if (ec) chk(y_valid == 1'b0, "R5 not yet valid", DW'(y_valid), 0);
        else    chk(y_valid == 1'b1, "R4 fast valid", DW'(y_valid), 1);
        @(negedge clk);
        a_valid = 1'b0; b_valid = 1'b0;
        if (newop >= 0) op_sel = newop[2:0];
        if (ec) begin
            @(posedge clk); #2;
            chk(y_valid == 1'b1, "R5 valid second edge", DW'(y_valid), 1);
        end
        chk(y_data == ed, tag, y_data, ed);
        chk(y_cond == ec, tag, DW'(y_cond), DW'(ec));
        chk(y_merge_err == ee, tag, DW'(y_merge_err), DW'(ee));
        @(posedge clk);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (stop_now()) begin
                bad++;
                total++;
                $display("FAIL watchdog expired");
                finish_up();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 chk(y_valid == 1'b0, "R1 valid in reset", DW'(y_valid), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        chk(y_valid == 1'b0, "R1 valid after reset", DW'(y_valid), 0);

        // R2 arithmetic and logic on true tokens
        run_tok(0, 32'd5, 1, 1, 32'd7, 1, 32'd12, 1, 0, "R2 add", -1);
        run_tok(1, 32'd3, 1, 1, 32'd5, 1, 32'hFFFF_FFFE, 1, 0, "R2 sub wrap", -1);
        run_tok(2, 32'hF0F0_1234, 1, 1, 32'hFF00_00FF, 1, 32'hF000_0034, 1, 0, "R2 and", -1);
        run_tok(3, 32'h0F00_0001, 1, 1, 32'h00F0_0010, 1, 32'h0FF0_0011, 1, 0, "R2 or", -1);
        run_tok(4, 32'hAAAA_5555, 1, 1, 32'hFFFF_0000, 1, 32'h5555_5555, 1, 0, "R2 xor", -1);

        // R3 false combined condition, R4 fast path
        run_tok(0, 32'd9, 1, 1, 32'd9, 0, 32'd0, 0, 0, "R3 and of conds, B false", -1);
        run_tok(4, 32'd1, 0, 1, 32'd2, 1, 32'd0, 0, 0, "R3 and of conds, A false", -1);

        // R6 routing uses only A
        run_tok(5, 32'hCAFE_0001, 1, 0, 32'd0, 0, 32'hCAFE_0001, 1, 0, "R6 route A", -1);
        run_tok(7, 32'h1234_5678, 1, 1, 32'h1, 0, 32'h1234_5678, 1, 0, "R6 route alt code", -1);
        run_tok(5, 32'h77, 0, 0, 32'd0, 1, 32'd0, 0, 0, "R6 route false", -1);

        // R8 merge arms
        run_tok(6, 32'h1111, 1, 1, 32'h2222, 0, 32'h1111, 1, 0, "R8 merge then", -1);
        run_tok(6, 32'h1111, 0, 1, 32'h2222, 1, 32'h2222, 1, 0, "R8 merge else", -1);
        run_tok(6, 32'h1111, 0, 1, 32'h2222, 0, 32'h0, 0, 0, "R8 merge both false", -1);
        run_tok(6, 32'h3333, 1, 1, 32'h4444, 1, 32'h3333, 1, 1, "R8 merge both true", -1);

        // R10 op change after acceptance
        run_tok(0, 32'd100, 1, 1, 32'd23, 1, 32'd123, 1, 0, "R10 op latched", 4);

        // R7 two-input op waits for B
        @(negedge clk);
        op_sel = 3'd1; a_valid = 1'b1; a_data = 32'd50; a_cond = 1'b1; b_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1 chk(a_ready == 1'b0, "R7 wait for B", DW'(a_ready), 0);
            @(negedge clk);
        end
        b_valid = 1'b1; b_data = 32'd8; b_cond = 1'b1;
        #1 chk(a_ready && b_ready, "R7 joint accept", DW'({a_ready, b_ready}), 3);
        @(negedge clk); a_valid = 1'b0; b_valid = 1'b0;
        @(negedge clk); #1 chk(y_data == 32'd42, "R7 result", y_data, 32'd42);

        // R9 backpressure holds the token and blocks input
        @(negedge clk); y_ready = 1'b0;
        present(0, 32'd10, 1, 1, 32'd20, 1);
        @(negedge clk);
        a_data = 32'd1; b_data = 32'd2;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(a_ready == 1'b0, "R9 no accept while held", DW'(a_ready), 0);
            chk(y_valid && y_data == 32'd30, "R9 token held", y_data, 32'd30);
        end
        y_ready = 1'b1;
        @(posedge clk); #2;
        chk(y_valid == 1'b0, "R9 drained", DW'(y_valid), 0);
        @(negedge clk); a_valid = 1'b0; b_valid = 1'b0;
        repeat (4) @(posedge clk);
        #2 chk(y_valid == 1'b0, "R9 idle after drain", DW'(y_valid), 0);

        finish_up();
    end

endmodule